// File: doc/BRIEF.md
# Supply-Fault Reset Supervisor

This block turns a digital "supply below trip level" indication into a system reset. It drives an active-low reset line that is open-drain in nature: the block only ever enables a pull-down, and when it releases the line an external weak pull-up, or another reset source wired onto the same node, decides the level. The reset is driven whenever the supply is low. After the supply recovers, the reset is held for a programmable number of clock cycles. That interval restarts from zero if the supply dips again before it ends. The same hold applies after power-up.

While reset is requested, the block also produces a lockout that stops the serial bus front end from accepting new traffic. The lockout arms only at a safe point: when the bus front end reports that it is between bytes, or when the memory write strobe for an in-flight write has just been issued. A write that began before the fault therefore always completes. A status flag shows when the block is in the recovery hold, meaning the supply is good but the reset is still being driven.

The fault input is asynchronous and passes through a two-stage synchroniser. The power-on reset input `porN` is asynchronous and active low.

Top module: `supply_reset_supervisor`

## Requirements
- R1: While `supplyLowRaw` is 1, `resetDriveLow` is 1 no later than the second rising clock edge after the edge that first samples it high, and it stays 1 while the input stays high.
- R2: Suppose the first rising edge that samples `supplyLowRaw` = 0 is edge 0, and the input then stays 0. `resetDriveLow` stays 1 through edge HOLD_CYCLES and goes to 0 after edge HOLD_CYCLES+1.
- R3: If the synchronised supply-low indication returns to 1 at any point during the recovery hold, including the last cycle of the hold, the hold count restarts from zero. Release then needs a full HOLD_CYCLES count of good supply.
- R4: While `porN` is 0, `resetDriveLow` = 1, `busLockout` = 1 and `holdActive` = 0. After `porN` rises, the supply is treated as low until the synchroniser has filled. A full hold then follows before release.
- R5: `holdActive` is 1 exactly when the synchronised supply is good and `resetDriveLow` is still 1.
- R6: While reset is requested, `busLockout` goes from 0 to 1 only after a clock edge at which `byteBoundary` = 1 or `memWriteStrobe` = 1. With both inputs at 0, the lockout does not arm.
- R7: `busLockout` returns to 0 one clock cycle after `resetDriveLow` returns to 0.
- R8: Once `busLockout` is 1, it stays 1 while reset is requested, whatever `byteBoundary` and `memWriteStrobe` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| supplyLowRaw | input | 1 | Asynchronous comparator result, 1 = supply below trip level |
| byteBoundary | input | 1 | 1 = the bus front end is between bytes (or idle) |
| memWriteStrobe | input | 1 | 1-cycle pulse when the memory write strobe of an in-flight write is issued |
| resetDriveLow | output | 1 | 1 = enable the pull-down on the active-low reset line |
| busLockout | output | 1 | 1 = serial bus front end must ignore new activity |
| holdActive | output | 1 | 1 = supply good, reset still held for the recovery interval |

## Verification
The sharpest collision is a fresh supply dip that reaches the synchroniser output in the same cycle the hold count would finish. In that cycle, the restart of the count has to win over release. The bench sweeps the timing of a short dip across the last few cycles of the hold, so the dip arrives just before, exactly at, and just after expiry. A reference model, built from queues and integers, is compared with every output on every clock.

The second collision is the lockout arming on a byte boundary or write strobe in the same cycle that the reset request drops. Random stimulus on `byteBoundary` and `memWriteStrobe` around each release provokes it, and the per-clock comparison judges that release takes priority.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  // Strobes issued by the control half to the datapath half each cycle.
  typedef struct packed {
    logic clearHold;    // restart the recovery count
    logic advanceHold;  // count one more good-supply cycle
    logic armLock;      // safe point reached while reset is requested
    logic dropLock;     // reset request gone, release the bus
  } holdStrobes_t;

endpackage

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
  import supply_reset_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         supplyLowRaw,
  input  logic         byteBoundary,
  input  logic         memWriteStrobe,
  input  logic         holdDone,
  output holdStrobes_t strobes,
  output logic         supplyLowSync,
  output logic         resetReq,
  output logic         holdActive
);

  localparam int SYNC_STAGES = 2;

  // Two-stage synchroniser; resets to "supply low" so power-up is a fault.
  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncChain <= '1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], supplyLowRaw};
    end
  end

  assign supplyLowSync = syncChain[SYNC_STAGES-1];

  // Reset is requested during a fault and until the hold has run out.
  assign resetReq   = supplyLowSync | ~holdDone;
  assign holdActive = ~supplyLowSync & ~holdDone;

  always_comb begin
    strobes             = '0;
    strobes.clearHold   = supplyLowSync;
    strobes.advanceHold = ~supplyLowSync & ~holdDone;
    strobes.armLock     = resetReq & (byteBoundary | memWriteStrobe);
    strobes.dropLock    = ~resetReq;
  end

endmodule

// File: rtl/supply_reset_dp.sv
module supply_reset_dp
  import supply_reset_pkg::*;
#(
  parameter int HOLD_CYCLES = 100000
) (
  input  logic         clk,
  input  logic         porN,
  input  holdStrobes_t strobes,
  output logic         holdDone,
  output logic         busLockout
);

  localparam int               CNT_W     = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;

  // Recovery counter: restarts on every fault cycle, stops at the limit.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= '0;
    end else if (strobes.clearHold) begin
      holdCnt <= '0;
    end else if (strobes.advanceHold) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  // Lockout register: release wins over arming.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busLockout <= 1'b1;
    end else if (strobes.dropLock) begin
      busLockout <= 1'b0;
    end else if (strobes.armLock) begin
      busLockout <= 1'b1;
    end
  end

endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor
  import supply_reset_pkg::*;
#(
  parameter int HOLD_CYCLES = 100000
) (
  input  logic clk,
  input  logic porN,
  input  logic supplyLowRaw,
  input  logic byteBoundary,
  input  logic memWriteStrobe,
  output logic resetDriveLow,
  output logic busLockout,
  output logic holdActive
);

  holdStrobes_t strobes;
  logic         holdDone;
  logic         supplyLowSync;
  logic         resetReq;

  supply_reset_ctrl u_ctrl (
    .clk            (clk),
    .porN           (porN),
    .supplyLowRaw   (supplyLowRaw),
    .byteBoundary   (byteBoundary),
    .memWriteStrobe (memWriteStrobe),
    .holdDone       (holdDone),
    .strobes        (strobes),
    .supplyLowSync  (supplyLowSync),
    .resetReq       (resetReq),
    .holdActive     (holdActive)
  );

  supply_reset_dp #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .strobes    (strobes),
    .holdDone   (holdDone),
    .busLockout (busLockout)
  );

  assign resetDriveLow = resetReq;

endmodule

// File: rtl/supply_reset_checker.sv
module supply_reset_checker #(
  parameter int HOLD_CYCLES = 100000
) (
  input logic clk,
  input logic porN,
  input logic supplyLowRaw,
  input logic byteBoundary,
  input logic memWriteStrobe,
  input logic supplyLowSync,
  input logic resetDriveLow,
  input logic busLockout,
  input logic holdActive
);

  // Good-supply run length seen at the synchroniser output (saturating).
  int goodRun;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      goodRun <= 0;
    end else if (supplyLowSync) begin
      goodRun <= 0;
    end else if (goodRun <= HOLD_CYCLES) begin
      goodRun <= goodRun + 1;
    end
  end

  // R1: a sampled fault reaches the reset drive within two edges
  a_r1_fault_drives_reset: assert property (@(posedge clk) disable iff (!porN)
    supplyLowRaw |=> ##1 resetDriveLow);

  // R2, R3: release only after a full uninterrupted run of good supply
  a_r3_full_hold_before_release: assert property (@(posedge clk) disable iff (!porN)
    $fell(resetDriveLow) |-> (goodRun >= HOLD_CYCLES));

  // R5: recovery-hold flag implies the reset is driven
  a_r5_hold_implies_reset: assert property (@(posedge clk) disable iff (!porN)
    holdActive |-> resetDriveLow);

  // R6: lockout arms only after a safe point was reported
  a_r6_arm_at_safe_point: assert property (@(posedge clk) disable iff (!porN)
    $rose(busLockout) |-> $past(byteBoundary || memWriteStrobe));

  // R7: lockout clears only after the reset was released
  a_r7_release_after_reset: assert property (@(posedge clk) disable iff (!porN)
    $fell(busLockout) |-> $past(!resetDriveLow));

  // R8: an armed lockout holds while the reset stays requested
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!porN)
    (busLockout && resetDriveLow) |=> busLockout);

endmodule

bind supply_reset_supervisor supply_reset_checker #(
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk            (clk),
  .porN           (porN),
  .supplyLowRaw   (supplyLowRaw),
  .byteBoundary   (byteBoundary),
  .memWriteStrobe (memWriteStrobe),
  .supplyLowSync  (supplyLowSync),
  .resetDriveLow  (resetDriveLow),
  .busLockout     (busLockout),
  .holdActive     (holdActive)
);

// File: tb/sim_supply_reset_supervisor.sv
module sim_supply_reset_supervisor;

  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyLowRaw = 1'b0;
  logic byteBoundary = 1'b0;
  logic memWriteStrobe = 1'b0;
  wire  resetDriveLow;
  wire  busLockout;
  wire  holdActive;

  always #4 clk = ~clk;  // 125 MHz

  supply_reset_supervisor #(.HOLD_CYCLES(HOLD)) u0 (
    .clk            (clk),
    .porN           (porN),
    .supplyLowRaw   (supplyLowRaw),
    .byteBoundary   (byteBoundary),
    .memWriteStrobe (memWriteStrobe),
    .resetDriveLow  (resetDriveLow),
    .busLockout     (busLockout),
    .holdActive     (holdActive)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string phaseTag = "R4";

  // Behavioural reference: a queue for the synchroniser, integers for the rest.
  bit syncQ[$] = '{1'b1, 1'b1};
  int goodCount = 0;
  bit lockRef = 1'b1;
  bit reqRef;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncQ = '{1'b1, 1'b1};
      goodCount = 0;
      lockRef = 1'b1;
    end else begin
      reqRef = syncQ[1] || (goodCount != HOLD);
      if (!reqRef) lockRef = 1'b0;
      else if (byteBoundary || memWriteStrobe) lockRef = 1'b1;
      if (syncQ[1]) goodCount = 0;
      else if (goodCount != HOLD) goodCount = goodCount + 1;
      syncQ.push_front(supplyLowRaw);
      void'(syncQ.pop_back());
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic expRst;
    logic expHold;
    expRst  = syncQ[1] || (goodCount != HOLD);
    expHold = !syncQ[1] && (goodCount != HOLD);
    chk(phaseTag, "resetDriveLow", resetDriveLow, expRst);
    chk("R5", "holdActive", holdActive, expHold);
    chk("R6 R7 R8", "busLockout", busLockout, lockRef);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    // R4: power-up, safe-point inputs active during porN must not matter
    phaseTag = "R4";
    byteBoundary = 1'b1;
    step(3);
    chk("R4", "reset state resetDriveLow", resetDriveLow, 1'b1);
    chk("R4", "reset state busLockout", busLockout, 1'b1);
    chk("R4", "reset state holdActive", holdActive, 1'b0);
    porN = 1'b1;
    step(HOLD + 6);
    chk("R4", "released after power-up hold", resetDriveLow, 1'b0);

    // R1 and R6: fault with no safe point, lockout must stay off
    phaseTag = "R1";
    byteBoundary = 1'b0;
    supplyLowRaw = 1'b1;
    step(6);
    chk("R6", "no arm without safe point", busLockout, 1'b0);
    chk("R1", "fault drives reset", resetDriveLow, 1'b1);
    memWriteStrobe = 1'b1;
    step(1);
    memWriteStrobe = 1'b0;
    step(1);
    chk("R6", "armed after write strobe", busLockout, 1'b1);
    byteBoundary = 1'b1;
    step(2);
    byteBoundary = 1'b0;

    // R2 and R7: recovery, exact release cycle, lockout follows one cycle later
    phaseTag = "R2";
    supplyLowRaw = 1'b0;
    step(HOLD + 1);
    chk("R2", "still held at end of count", resetDriveLow, 1'b1);
    step(1);
    chk("R2", "released after full hold", resetDriveLow, 1'b0);
    chk("R7", "lockout one cycle behind", busLockout, 1'b1);
    step(1);
    chk("R7", "lockout released", busLockout, 1'b0);
    step(2);

    // R3: a short dip swept across the last cycles of the hold
    phaseTag = "R3";
    for (int k = HOLD - 3; k <= HOLD + 1; k++) begin
      supplyLowRaw = 1'b1;
      byteBoundary = k[0];
      step(3);
      supplyLowRaw = 1'b0;
      step(k);
      supplyLowRaw = 1'b1;
      step(1);
      supplyLowRaw = 1'b0;
      byteBoundary = 1'b1;
      step(HOLD + 5);
    end

    // Random mix, release and arming collide here
    phaseTag = "R1 R2 R3";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 29) == 0) supplyLowRaw = ~supplyLowRaw;
      byteBoundary   = ($urandom_range(0, 3) == 0);
      memWriteStrobe = ($urandom_range(0, 7) == 0);
      step(1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule